// File: doc/BRIEF.md
# Fast Edge-Triggered Interrupt Front End

This block sits between eight interrupt inputs and the CPU interrupt controller. For each channel it picks either an external pin or an internal peripheral signal, such as a bus receive line, a serial clock or a timer alarm. It then passes the chosen signal through a two-flop synchronizer and compares each new sample with the one before it. A channel raises a sticky request on the edge that its 2-bit mode field selects: rising, falling or either. The request stays set until the interrupt acknowledge clears it. Arbitration downstream only looks at requests once every four cycles, so the hold matters. The block also gives the slot strobe for that arbitration rhythm.

The same 2-bit mode also sets a level rule for power-down. Each enabled channel either allows the chip to enter power-down or blocks it, and it can ask for a wake-up. The block combines these per-channel conditions into one registered permit and one registered wake output. The wake output is active only while the global power-down configuration input is set. A real-time-clock alarm only gives positive edges, so a channel fed from it should use the rising mode.

Top module: `fxi_edge_ctrl`

## Requirements
- R1: The mode register is 2*NCH bits wide. Channel x's mode lives in bits [2x+1:2x]. The register loads from `cfg_wdata` on a cycle with `cfg_we` high, and it reads back on `cfg_rdata` on the next cycle.
- R2: During and after reset, `cfg_rdata` is 0, every `irq_pend` bit is 0, `pd_wake` is 0 and `pd_permit` is 1.
- R3: Mode 00 turns the channel off. An edge on it never sets its pending bit, and its level has no effect on `pd_wake` or `pd_permit`.
- R4: In mode 01, a rising edge sets the pending bit and a falling edge does not. The channel permits power-down while its input is 0 and requests wake while its input is 1.
- R5: In mode 10, a falling edge sets the pending bit and a rising edge does not. The channel permits power-down while its input is 1 and requests wake while its input is 0.
- R6: In mode 11, both edges set the pending bit. The channel always permits power-down and requests wake for exactly one cycle after each change of its input.
- R7: A change on the selected input shows on `irq_pend`, `pd_wake` and `pd_permit` just after the third rising clock edge that follows it, and not before.
- R8: A pending bit stays set until its `ack_clr` bit is high for a cycle. If a qualifying edge lands in the same cycle as the clear, the bit stays set.
- R9: `arb_slot` is high for exactly one cycle out of every ARB_PERIOD (4) cycles. Pending bits hold across any number of slots.
- R10: Source select bit x, loaded from `src_wdata` when `src_we` is high, picks `alt_in[x]` when it is 1 and `pin_in[x]` when it is 0. The input that is not selected has no effect.
- R11: `pd_wake` is the registered OR of the enabled channels' wake conditions, forced to 0 while `pd_cfg_en` is 0. `pd_permit` is the registered AND of the enabled channels' enter conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the mode register |
| cfg_wdata | input | 2*NCH | New mode register value |
| src_we | input | 1 | Write strobe for the source-select register |
| src_wdata | input | NCH | New source-select value (1 = internal source) |
| pd_cfg_en | input | 1 | Global power-down wake enable |
| pin_in | input | NCH | External pins |
| alt_in | input | NCH | Internal peripheral sources |
| ack_clr | input | NCH | Per-channel pending clear from the interrupt acknowledge |
| cfg_rdata | output | 2*NCH | Current mode register |
| irq_pend | output | NCH | Sticky pending requests |
| arb_slot | output | 1 | Arbitration slot strobe |
| pd_wake | output | 1 | Power-down wake request |
| pd_permit | output | 1 | Power-down entry allowed |

## Verification
A stale previous-sample register shows up at the ports in one of two ways. A request can appear with no edge at the input, or a real edge can be missed. Either error is visible on `irq_pend` three cycles after the input moves. A wrong mode decode or source select shows up on `pd_wake` and `pd_permit` in that same cycle, because both are built from the synchronized level. A slot counter that drifts shows at once as uneven spacing of `arb_slot`. A pending bit that clears wrongly shows the cycle after the acknowledge, or after the colliding edge.

// File: rtl/fxi_pkg.sv
package fxi_pkg;
  typedef enum logic [1:0] {
    EM_OFF  = 2'b00,
    EM_RISE = 2'b01,
    EM_FALL = 2'b10,
    EM_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/fxi_sync.sv
module fxi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fxi_channel.sv
module fxi_channel
  import fxi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  edge_mode_e mode,
  input  logic       smp,
  input  logic       clr,
  output logic       pend,
  output logic       wake_c,
  output logic       enter_c
);
  logic prev;
  logic rise, fall, hit;

  assign rise = smp & ~prev;
  assign fall = ~smp & prev;

  always_comb begin
    hit     = 1'b0;
    wake_c  = 1'b0;
    enter_c = 1'b1;
    case (mode)
      EM_RISE: begin hit = rise;        wake_c = smp;         enter_c = ~smp; end
      EM_FALL: begin hit = fall;        wake_c = ~smp;        enter_c = smp;  end
      EM_ANY:  begin hit = rise | fall; wake_c = rise | fall; enter_c = 1'b1; end
      default: begin hit = 1'b0;        wake_c = 1'b0;        enter_c = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      pend <= 1'b0;
    end else begin
      prev <= smp;
      pend <= hit | (pend & ~clr);
    end
  end

  // R3: a disabled channel never raises a request
  assert_off_no_set_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == EM_OFF && !pend) |=> !pend);
  // R8: request holds until acknowledged
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
  // R8: clear without a competing edge drops the request
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !pend);
endmodule

// File: rtl/fxi_slot_tick.sv
module fxi_slot_tick #(
  parameter int PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  output logic slot
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      slot <= 1'b0;
    end else begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      slot <= (cnt == LAST);
    end
  end

  // R9: never two slot strobes back to back
  assert_slot_gap_R9: assert property (@(posedge clk) disable iff (rst)
    slot |=> !slot);
endmodule

// File: rtl/fxi_edge_ctrl.sv
module fxi_edge_ctrl
  import fxi_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ARB_PERIOD  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2*NCH-1:0] cfg_wdata,
  input  logic             src_we,
  input  logic [NCH-1:0]   src_wdata,
  input  logic             pd_cfg_en,
  input  logic [NCH-1:0]   pin_in,
  input  logic [NCH-1:0]   alt_in,
  input  logic [NCH-1:0]   ack_clr,
  output logic [2*NCH-1:0] cfg_rdata,
  output logic [NCH-1:0]   irq_pend,
  output logic             arb_slot,
  output logic             pd_wake,
  output logic             pd_permit
);
  localparam int CFGW = 2 * NCH;

  logic [CFGW-1:0] cfg_q;
  logic [NCH-1:0]  src_q;
  logic [NCH-1:0]  wake_v, enter_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      src_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (src_we) src_q <= src_wdata;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic raw, smp;
    assign raw = src_q[i] ? alt_in[i] : pin_in[i];

    fxi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw),
      .q   (smp)
    );

    fxi_channel u_ch (
      .clk     (clk),
      .rst     (rst),
      .mode    (edge_mode_e'(cfg_q[2*i +: 2])),
      .smp     (smp),
      .clr     (ack_clr[i]),
      .pend    (irq_pend[i]),
      .wake_c  (wake_v[i]),
      .enter_c (enter_v[i])
    );
  end

  fxi_slot_tick #(.PERIOD(ARB_PERIOD)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .slot (arb_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_wake   <= 1'b0;
      pd_permit <= 1'b1;
    end else begin
      pd_wake   <= pd_cfg_en & (|wake_v);
      pd_permit <= &enter_v;
    end
  end

  assign cfg_rdata = cfg_q;

  // R2: reset leaves every mode off
  assert_reset_cfg_R2: assert property (@(posedge clk)
    rst |=> (cfg_rdata == '0));
  // R11: wake is blocked while power-down wake is disabled
  assert_wake_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !pd_cfg_en |=> !pd_wake);
  // R3: all channels off means no wake and entry permitted
  assert_all_off_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_q == '0) |=> (!pd_wake && pd_permit));
endmodule

// File: tb/fxi_edge_ctrl_tb.sv
module fxi_edge_ctrl_tb;
  localparam int NCH = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             cfg_we;
  logic [2*NCH-1:0] cfg_wdata;
  logic             src_we;
  logic [NCH-1:0]   src_wdata;
  logic             pd_cfg_en;
  logic [NCH-1:0]   pin_in, alt_in, ack_clr;
  logic [2*NCH-1:0] cfg_rdata;
  logic [NCH-1:0]   irq_pend;
  logic             arb_slot, pd_wake, pd_permit;

  always #2.5 clk = ~clk;

  fxi_edge_ctrl #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .src_we(src_we), .src_wdata(src_wdata), .pd_cfg_en(pd_cfg_en),
    .pin_in(pin_in), .alt_in(alt_in), .ack_clr(ack_clr),
    .cfg_rdata(cfg_rdata), .irq_pend(irq_pend), .arb_slot(arb_slot),
    .pd_wake(pd_wake), .pd_permit(pd_permit)
  );

  typedef struct {
    int         cyc;
    logic [7:0] pend;
    logic       wake;
    logic       permit;
    string      req;
  } exp_t;

  exp_t sb[$];
  int   cyc_cnt = 0;
  int   checks = 0;
  int   fails = 0;
  bit   finished = 0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int cyc, logic [7:0] p, logic w, logic pm, string req);
    exp_t e;
    e.cyc = cyc; e.pend = p; e.wake = w; e.permit = pm; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare every scoreboard entry due this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc_cnt) begin
        chk(sb[i].req, "irq_pend", {24'd0, irq_pend}, {24'd0, sb[i].pend});
        chk(sb[i].req, "pd_wake", {31'd0, pd_wake}, {31'd0, sb[i].wake});
        chk(sb[i].req, "pd_permit", {31'd0, pd_permit}, {31'd0, sb[i].permit});
        sb.delete(i);
      end
    end
  end

  // driver: apply inputs at a negedge, expect the result three edges later
  task automatic step(logic [7:0] pin, logic [7:0] alt, logic [7:0] ack,
                      logic [7:0] ep, logic ew, logic epm, string req);
    @(negedge clk);
    pin_in = pin; alt_in = alt; ack_clr = ack;
    push(cyc_cnt + 3, ep, ew, epm, req);
    @(negedge clk);
    ack_clr = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      foreach (sb[i]) begin
        fails++;
        $display("FAIL %s scoreboard entry never compared actual=none expected=cycle %0d",
                 sb[i].req, sb[i].cyc);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n_slot;
    bit back2back;
    rst = 1'b1; cfg_we = 0; cfg_wdata = '0; src_we = 0; src_wdata = '0;
    pd_cfg_en = 1'b1; pin_in = 8'h02; alt_in = '0; ack_clr = '0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2", "cfg_rdata", {16'd0, cfg_rdata}, 32'h0);
    chk("R2", "irq_pend", {24'd0, irq_pend}, 32'h0);
    chk("R2", "pd_wake", {31'd0, pd_wake}, 32'h0);
    chk("R2", "pd_permit", {31'd0, pd_permit}, 32'h1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R3: ch1 went high while its mode was off
    chk("R3", "irq_pend", {24'd0, irq_pend}, 32'h0);
    chk("R3", "pd_permit", {31'd0, pd_permit}, 32'h1);

    // R1: ch0=01, ch1=10, ch2=11, ch3=00
    cfg_we = 1'b1; cfg_wdata = 16'h0039;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R1", "cfg_rdata", {16'd0, cfg_rdata}, 32'h39);
    repeat (3) @(negedge clk);

    // R4 rising on ch0, with R7 latency check one edge early
    push(cyc_cnt + 3, 8'h00, 1'b0, 1'b1, "R7");
    step(8'h03, 8'h00, 8'h00, 8'h01, 1'b1, 1'b0, "R4");
    step(8'h02, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1, "R4");
    // R5 falling on ch1, then rising does not set and the request sticks
    step(8'h00, 8'h00, 8'h00, 8'h02, 1'b1, 1'b0, "R5");
    step(8'h02, 8'h00, 8'h00, 8'h02, 1'b0, 1'b1, "R8");
    // R6 any edge on ch2: one-cycle wake
    push(cyc_cnt + 5, 8'h06, 1'b0, 1'b1, "R6");
    step(8'h06, 8'h00, 8'h00, 8'h06, 1'b1, 1'b1, "R6");
    step(8'h02, 8'h00, 8'h06, 8'h04, 1'b1, 1'b1, "R6");
    // R3: ch3 off, edges ignored
    step(8'h0A, 8'h00, 8'h04, 8'h00, 1'b0, 1'b1, "R3");
    step(8'h02, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R3");
    // R11: wake gated off, permit still reflects ch1 low
    @(negedge clk); pd_cfg_en = 1'b0;
    step(8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 1'b0, "R11");
    @(negedge clk); pd_cfg_en = 1'b1;
    step(8'h02, 8'h00, 8'h02, 8'h00, 1'b0, 1'b1, "R11");

    // R10: ch0 takes the internal source
    @(negedge clk); src_we = 1'b1; src_wdata = 8'h01;
    @(negedge clk); src_we = 1'b0;
    repeat (3) @(negedge clk);
    step(8'h03, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R10");
    step(8'h03, 8'h01, 8'h00, 8'h01, 1'b1, 1'b0, "R10");
    step(8'h02, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1, "R10");

    // R8: edge and clear in the same cycle, edge wins (ch2, mode 11)
    step(8'h06, 8'h00, 8'h00, 8'h04, 1'b1, 1'b1, "R8");
    @(negedge clk);
    pin_in = 8'h02;
    push(cyc_cnt + 3, 8'h04, 1'b1, 1'b1, "R8");
    repeat (2) @(negedge clk);
    ack_clr = 8'h04;
    @(negedge clk);
    ack_clr = '0;
    repeat (2) @(negedge clk);
    step(8'h02, 8'h00, 8'h04, 8'h00, 1'b0, 1'b1, "R8");

    // R9: slot spacing, and a pending request held across slots
    step(8'h00, 8'h00, 8'h00, 8'h02, 1'b1, 1'b0, "R9");
    n_slot = 0; back2back = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (arb_slot) begin
        n_slot++;
        @(negedge clk);
        k++;
        if (arb_slot) back2back = 1;
      end
    end
    chk("R9", "slot count", n_slot, 10);
    chk("R9", "back-to-back slot", {31'd0, back2back}, 32'h0);
    chk("R9", "held irq_pend", {24'd0, irq_pend}, 32'h02);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule